// File: doc/BRIEF.md
# GPIO Controller with Edge Interrupts

This peripheral drives and samples up to 64 general-purpose pins. The pins are split into register sets of 32. Each set holds a direction register, an output latch, a synchronised input readback, per-pin rising and falling edge enables, and an interrupt status register that is cleared by writing ones. The output latch and the edge enables are never written directly. They change only through paired set-ones and clear-ones ports, so software can change single bits without a read-modify-write sequence.

Each 16-bit half of a status register feeds its own bank interrupt line. Every line is gated by one bit of a global bank-enable register. Software uses a simple register bus: a write takes effect at the clock edge where it is presented. A read is captured at that edge and returned one cycle later with `bus_rvalid`. The bus has no back-pressure and accepts one access per cycle.

Address map: the bank-enable register is at 0x08. Register set k starts at 0x10 + 0x28*k and holds ten words at 4-byte spacing. The word offsets are: 0x00 direction, 0x04 output latch (read-only), 0x08 latch set, 0x0C latch clear, 0x10 input, 0x14 rising set, 0x18 rising clear, 0x1C falling set, 0x20 falling clear, 0x24 status. Unmapped addresses read as zero.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, every direction bit is 1, and the output latches, edge enables, status bits and bank enables are all 0. `pin_oe` and `bank_irq` are 0.
- R2: For each pin, a direction bit of 1 makes the pin an input (`pin_oe` low). A direction bit of 0 makes it an output (`pin_oe` high), driving the latch value on `pin_out`. A direction write takes effect at its clock edge.
- R3: Writing to the latch-set port (offset 0x08) sets the latch bits written as 1. Writing to the latch-clear port (0x0C) clears the latch bits written as 1. Bits written as 0 keep their value. Writes to the latch word (0x04) are ignored. Reading 0x04, 0x08 or 0x0C returns the latch.
- R4: The input word (0x10) returns the pin level after a two-flop synchroniser, including for pins that are outputs. A pin change is visible to a read issued two cycles after the change.
- R5: The rising-set and rising-clear ports (0x14, 0x18) and the falling-set and falling-clear ports (0x1C, 0x20) set or clear the edge enables bit by bit. Both edges may be enabled on one pin. Reading either port of a pair returns that enable word.
- R6: A synchronised 0-to-1 transition on a pin with its rising enable set, or a 1-to-0 transition with its falling enable set, sets that pin's status bit three clock edges after the pin changes. Transitions on pins without the matching enable leave status unchanged.
- R7: Writing 1 to a status bit clears it, and status bits written as 0 are unchanged. A status bit is set whatever the bank-enable value.
- R8: When a detected edge and a status clear write hit the same bit at the same clock edge, the bit ends up set.
- R9: Status bits 15..0 of set k drive `bank_irq[2k]`, and bits 31..16 drive `bank_irq[2k+1]`. Line N is high only while bit N of the bank-enable register (0x08) is 1 and its half holds a set status bit.
- R10: Register set 1 sits at 0x38 and drives pins 63..32. It works independently of set 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data returned this cycle |
| pin_in | input | 64 | Pin levels, asynchronous |
| pin_out | output | 64 | Output latch values |
| pin_oe | output | 64 | Output enable per pin |
| bank_irq | output | 4 | Half-bank interrupt lines |

## Verification
The edge detector and the status clear port can act on the same status bit at the same clock edge. The bench first clears the status and moves a pin with its rising enable set. It then counts two edges from the pin change, so that the edge is detected exactly as a write of 1 to that status bit is presented, and expects the bit to read back set. A plain clear write without a concurrent edge is then checked to read back zero. This shows that the set-wins result comes from the collision and not from a clear port that does nothing.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  typedef enum logic [3:0] {
    RI_DIR  = 4'd0,
    RI_OUT  = 4'd1,
    RI_SET  = 4'd2,
    RI_CLR  = 4'd3,
    RI_IN   = 4'd4,
    RI_RSET = 4'd5,
    RI_RCLR = 4'd6,
    RI_FSET = 4'd7,
    RI_FCLR = 4'd8,
    RI_STAT = 4'd9
  } reg_idx_e;

  localparam int REGS_PER_SET = 10;
  localparam int BEN_OFS      = 8;
  localparam int SET_BASE     = 16;
  localparam int SET_STRIDE   = 40;

  function automatic int reg_addr(int set_no, reg_idx_e r);
    return SET_BASE + set_no * SET_STRIDE + 4 * int'(r);
  endfunction
endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_i;
      stab_q <= meta_q;
    end
  end

  assign sync_o = stab_q;
endmodule

// File: rtl/gpio_edge_set.sv
module gpio_edge_set
  import gpio_edge_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_stb,
  input  reg_idx_e     wr_idx,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] sync_in,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] out_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] dir_q, out_q, rise_q, fall_q, stat_q, prev_q;
  logic [W-1:0] edge_hit, clr_mask;

  assign edge_hit = (rise_q & sync_in & ~prev_q) | (fall_q & ~sync_in & prev_q);
  assign clr_mask = (wr_stb && wr_idx == RI_STAT) ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '1;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      stat_q <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= sync_in;
      stat_q <= (stat_q & ~clr_mask) | edge_hit;
      if (wr_stb) begin
        case (wr_idx)
          RI_DIR:  dir_q  <= wdata;
          RI_SET:  out_q  <= out_q | wdata;
          RI_CLR:  out_q  <= out_q & ~wdata;
          RI_RSET: rise_q <= rise_q | wdata;
          RI_RCLR: rise_q <= rise_q & ~wdata;
          RI_FSET: fall_q <= fall_q | wdata;
          RI_FCLR: fall_q <= fall_q & ~wdata;
          default: ;
        endcase
      end
    end
  end

  assign dir_o  = dir_q;
  assign out_o  = out_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;
  assign stat_o = stat_q;
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int NUM_SETS = 2,
  parameter int SET_W    = 32,
  parameter int ADDR_W   = 8,
  localparam int PINS    = NUM_SETS * SET_W,
  localparam int NBANK   = NUM_SETS * 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [SET_W-1:0]  bus_wdata,
  output logic [SET_W-1:0]  bus_rdata,
  output logic              bus_rvalid,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  output logic [NBANK-1:0]  bank_irq
);
  localparam int HALF = SET_W / 2;
  localparam logic [ADDR_W-1:0] BEN_A = ADDR_W'(BEN_OFS);

  logic [PINS-1:0]  pin_sync;
  logic [NBANK-1:0] ben_q;
  logic [SET_W-1:0] set_rd [NUM_SETS];
  logic [SET_W-1:0] rd_word;

  gpio_edge_sync #(.W(PINS)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(pin_in),
    .sync_o (pin_sync)
  );

  for (genvar k = 0; k < NUM_SETS; k++) begin : g_set
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(SET_BASE + k * SET_STRIDE);
    logic [ADDR_W-1:0] ofs;
    logic              hit;
    reg_idx_e          idx;
    logic [SET_W-1:0]  dir_w, out_w, rise_w, fall_w, stat_w, in_w;

    assign ofs  = bus_addr - BASE;
    assign hit  = (bus_addr >= BASE) && (ofs < ADDR_W'(4 * REGS_PER_SET)) && (ofs[1:0] == 2'b00);
    assign idx  = reg_idx_e'(ofs[5:2]);
    assign in_w = pin_sync[k*SET_W +: SET_W];

    gpio_edge_set #(.W(SET_W)) u_set (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_stb (bus_en && bus_we && hit),
      .wr_idx (idx),
      .wdata  (bus_wdata),
      .sync_in(in_w),
      .dir_o  (dir_w),
      .out_o  (out_w),
      .rise_o (rise_w),
      .fall_o (fall_w),
      .stat_o (stat_w)
    );

    always_comb begin
      set_rd[k] = '0;
      if (hit) begin
        case (idx)
          RI_DIR:                  set_rd[k] = dir_w;
          RI_OUT, RI_SET, RI_CLR:  set_rd[k] = out_w;
          RI_IN:                   set_rd[k] = in_w;
          RI_RSET, RI_RCLR:        set_rd[k] = rise_w;
          RI_FSET, RI_FCLR:        set_rd[k] = fall_w;
          RI_STAT:                 set_rd[k] = stat_w;
          default:                 set_rd[k] = '0;
        endcase
      end
    end

    assign pin_out[k*SET_W +: SET_W] = out_w;
    assign pin_oe[k*SET_W +: SET_W]  = ~dir_w;
    assign bank_irq[2*k]   = ben_q[2*k]   & (|stat_w[HALF-1:0]);
    assign bank_irq[2*k+1] = ben_q[2*k+1] & (|stat_w[SET_W-1:HALF]);
  end

  always_comb begin
    rd_word = (bus_addr == BEN_A) ? SET_W'(ben_q) : '0;
    for (int k = 0; k < NUM_SETS; k++) rd_word = rd_word | set_rd[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ben_q      <= '0;
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_en && !bus_we;
      if (bus_en && !bus_we) bus_rdata <= rd_word;
      if (bus_en && bus_we && bus_addr == BEN_A) ben_q <= bus_wdata[NBANK-1:0];
    end
  end
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk
  import gpio_edge_pkg::*;
#(
  parameter int NUM_SETS = 2,
  parameter int SET_W    = 32,
  parameter int ADDR_W   = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       bus_en,
  input logic                       bus_we,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic [SET_W-1:0]           bus_wdata,
  input logic [NUM_SETS*SET_W-1:0]  pin_out,
  input logic [NUM_SETS*SET_W-1:0]  pin_oe,
  input logic [NUM_SETS*2-1:0]      bank_irq,
  input logic [NUM_SETS*2-1:0]      ben_q
);
  localparam logic [ADDR_W-1:0] A_DIR0 = ADDR_W'(reg_addr(0, RI_DIR));
  localparam logic [ADDR_W-1:0] A_SET0 = ADDR_W'(reg_addr(0, RI_SET));
  localparam logic [ADDR_W-1:0] A_CLR0 = ADDR_W'(reg_addr(0, RI_CLR));

  logic wr_set0, wr_clr0, wr_dir0;
  assign wr_set0 = bus_en && bus_we && bus_addr == A_SET0;
  assign wr_clr0 = bus_en && bus_we && bus_addr == A_CLR0;
  assign wr_dir0 = bus_en && bus_we && bus_addr == A_DIR0;

  AST_SET_PORT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set0 |=> ((pin_out[SET_W-1:0] & $past(bus_wdata)) == $past(bus_wdata))); // R3
  AST_CLR_PORT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr0 |=> ((pin_out[SET_W-1:0] & $past(bus_wdata)) == '0)); // R3
  AST_SET_PORT_ZEROS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set0 |=> ((pin_out[SET_W-1:0] & ~$past(bus_wdata)) == ($past(pin_out[SET_W-1:0]) & ~$past(bus_wdata)))); // R3
  AST_DIR_DRIVES_OE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir0 |=> (pin_oe[SET_W-1:0] == ~$past(bus_wdata))); // R2
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    bank_irq[0] |-> ben_q[0]); // R9
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(
  .NUM_SETS(NUM_SETS),
  .SET_W   (SET_W),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_en   (bus_en),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .pin_out  (pin_out),
  .pin_oe   (pin_oe),
  .bank_irq (bank_irq),
  .ben_q    (ben_q)
);

// File: tb/gpio_edge_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_edge_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [63:0] pin_in = '0;
  logic [63:0] pin_out;
  logic [63:0] pin_oe;
  logic [3:0]  bank_irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  localparam logic [7:0] BEN = 8'h08;
  localparam logic [7:0] DIR0 = 8'h10, OUT0 = 8'h14, SET0 = 8'h18, CLR0 = 8'h1C, IN0 = 8'h20;
  localparam logic [7:0] RS0 = 8'h24, RC0 = 8'h28, FS0 = 8'h2C, FC0 = 8'h30, ST0 = 8'h34;
  localparam logic [7:0] DIR1 = 8'h38, OUT1 = 8'h3C, SET1 = 8'h40, IN1 = 8'h48, RS1 = 8'h4C, ST1 = 8'h5C;

  always #2.5 clk = ~clk;

  gpio_edge_ctrl u_gpio_edge_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .bank_irq(bank_irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (bus_rvalid && !done) begin
      if (exp_q.size() == 0) chk("scoreboard unexpected read", 64'(bus_rdata), 64'hx);
      else chk(tag_q.pop_front(), 64'(bus_rdata), 64'(exp_q.pop_front()));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 pin_oe at reset", pin_oe, 64'h0);
    chk("R1 bank_irq at reset", 64'(bank_irq), 64'h0);
    rd(DIR0, 32'hFFFF_FFFF, "R1 dir0 reset");
    rd(DIR1, 32'hFFFF_FFFF, "R1 dir1 reset");
    rd(OUT0, 32'h0, "R1 latch reset");
    rd(ST0, 32'h0, "R1 status reset");
    rd(BEN, 32'h0, "R1 bank enable reset");
    rd(RS1, 32'h0, "R1 rise enable reset");

    // R2 direction
    wr(DIR0, 32'hFFFF_0000);
    chk("R2 oe follows direction", pin_oe, 64'h0000_0000_0000_FFFF);

    // R3 latch set/clear ports
    wr(SET0, 32'hA5A5_00F0);
    chk("R3 set port", pin_out, 64'h0000_0000_A5A5_00F0);
    wr(CLR0, 32'h0000_0030);
    chk("R3 clear port", pin_out, 64'h0000_0000_A5A5_00C0);
    wr(OUT0, 32'hFFFF_FFFF);
    chk("R3 latch word write ignored", pin_out, 64'h0000_0000_A5A5_00C0);
    rd(OUT0, 32'hA5A5_00C0, "R3 read latch");
    rd(SET0, 32'hA5A5_00C0, "R3 read set port");
    rd(CLR0, 32'hA5A5_00C0, "R3 read clear port");

    // R4 synchronised input, output pins included
    pin_in[31:0] = 32'h1234_5678;
    idle(3);
    rd(IN0, 32'h1234_5678, "R4 input readback");

    // R5 edge enables
    wr(RS0, 32'h3);
    wr(FS0, 32'h6);
    wr(RC0, 32'h1);
    rd(RS0, 32'h2, "R5 rise set port read");
    rd(RC0, 32'h2, "R5 rise clear port read");
    rd(FS0, 32'h6, "R5 fall set port read");
    rd(FC0, 32'h6, "R5 fall clear port read");

    // R6 edge detection
    pin_in[31:0] = 32'h1234_567F;
    idle(4);
    rd(ST0, 32'h2, "R6 rising edges");
    pin_in[31:0] = 32'h1234_5678;
    idle(4);
    rd(ST0, 32'h6, "R6 falling edges");

    // R9 bank gating, status set regardless (R7)
    chk("R9 no irq with bank disabled", 64'(bank_irq), 64'h0);
    wr(BEN, 32'h1);
    chk("R9 low half line", 64'(bank_irq), 64'h1);
    rd(BEN, 32'h1, "R9 bank enable read");
    wr(BEN, 32'h2);
    chk("R9 high half line quiet", 64'(bank_irq), 64'h0);
    wr(BEN, 32'h1);

    // R7 write-one-to-clear
    wr(ST0, 32'h4);
    rd(ST0, 32'h2, "R7 partial clear");
    chk("R7 irq still high", 64'(bank_irq), 64'h1);
    wr(ST0, 32'h2);
    rd(ST0, 32'h0, "R7 full clear");
    chk("R7 irq drops", 64'(bank_irq), 64'h0);

    // R8 edge and clear on the same edge: set wins
    pin_in[31:0] = 32'h1234_567A;
    idle(2);
    wr(ST0, 32'h2);
    rd(ST0, 32'h2, "R8 set wins over clear");
    wr(ST0, 32'h2);
    rd(ST0, 32'h0, "R8 clear without edge");

    // R10 second register set
    wr(DIR1, 32'h0);
    wr(SET1, 32'h8000_0001);
    chk("R10 set1 oe", pin_oe, 64'hFFFF_FFFF_0000_FFFF);
    chk("R10 set1 latch", pin_out, 64'h8000_0001_A5A5_00C0);
    rd(OUT1, 32'h8000_0001, "R10 set1 latch read");
    wr(RS1, 32'h0001_0000);
    pin_in[63:32] = 32'h0001_0000;
    idle(4);
    rd(ST1, 32'h0001_0000, "R10 set1 status");
    rd(IN1, 32'h0001_0000, "R10 set1 input");
    rd(ST0, 32'h0, "R10 set0 untouched");
    chk("R10 set1 high line gated", 64'(bank_irq), 64'h0);
    wr(BEN, 32'h8);
    chk("R10 set1 high line", 64'(bank_irq), 64'h8);

    idle(3);
    chk("scoreboard drained", 64'(exp_q.size()), 64'h0);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule